// File: doc/BRIEF.md
# Multi-Register Stack Save/Restore Sequencer

This block carries out a save or a restore of a chosen set of CPU registers to or from a descending stack. It moves one 32-bit word per cycle. An 8-bit selection mask names the registers: four upper bits each pick one general register, and one bit picks a fixed bank of seven registers together with one padding word. The three low bits have no meaning. A save walks the stack downward, decrementing before each store. A restore walks upward through the same slots in exactly the reverse order, so a restore undoes a save of the same mask.

The sequencer reads register values through a combinational read port and issues word store requests. For a restore it issues word loads whose data is written straight back through a register write port in the same cycle. The memory answers a load within the same cycle. The stack pointer itself is only reported once, at the end, together with a one-cycle done pulse. While a sequence runs, busy is high and further start pulses are dropped.

The controller has three states. `ST_IDLE` waits for start. It goes to `ST_RUN` when the mask selects at least one slot, and straight to `ST_DONE` when it selects none. `ST_RUN` executes the lowest pending slot each cycle and stays there while slots remain. After the last slot it goes to `ST_DONE`. `ST_DONE` pulses done with the final pointer and always returns to `ST_IDLE`.

Top module: `regstack_seq`

## Requirements
- R1: Register numbering on the read and write ports is D0..D3 = 0..3, A0..A3 = 4..7, MDR = 8, LIR = 9, LAR = 10. In a save (pop=0), mask bit 7 stores D2, then bit 6 stores D3, then bit 5 stores A2, then bit 4 stores A3. Each store first lowers the pointer by 4 and then writes at the new pointer, so consecutive stores fall at addresses 4 apart going down.
- R2: In a save, mask bit 3 stores D0, D1, A0, A1, MDR, LIR, LAR in that order after the bit 7..4 registers. It then lowers the pointer by a further 4 in one cycle with no memory request.
- R3: In a restore (pop=1), mask bit 3 is handled first. One cycle with no request raises the pointer by 4. Then LAR, LIR, MDR, A1, A0, D1, D0 are loaded from the current pointer, raising it by 4 after each load. Each loaded word appears on the register write port in the cycle of its load.
- R4: In a restore, the bit 3 bank is followed by bit 4 (A3), bit 5 (A2), bit 6 (D3), bit 7 (D2), each a load followed by a raise of 4. A restore of a mask undoes a save of the same mask.
- R5: The final pointer is output exactly once per sequence on sp_wdata with sp_we, in the same cycle as done. sp_we is never high otherwise.
- R6: Mask bits 2..0 have no effect on the operations, the timing or the final pointer.
- R7: A mask whose bits 7..3 are all zero gives done with sp_wdata equal to sp_in in the cycle right after start is accepted, and makes no memory request.
- R8: busy is high from the cycle after an accepted start until done, inclusive. A start while busy is ignored.
- R9: A sequence of N slots (one per selected register, plus one for the bit 3 padding word) takes N cycles of RUN. Done comes N+1 cycles after the accepted start. There is at most one memory request per cycle.
- R10: After reset the block is idle: busy, done, mem_req, rf_we and sp_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| pop | input | 1 | 0 = save to stack, 1 = restore from stack |
| mask | input | 8 | Register selection mask |
| sp_in | input | 32 | Stack pointer at start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Word memory request this cycle |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, same cycle |
| rf_rd_idx | output | 4 | Register read select |
| rf_rd_data | input | 32 | Register read data |
| rf_we | output | 1 | Register write enable |
| rf_wr_idx | output | 4 | Register write select |
| rf_wr_data | output | 32 | Register write data |
| sp_we | output | 1 | Final stack pointer valid |
| sp_wdata | output | 32 | Final stack pointer |

## Verification
The bench checks that a full-mask save followed by a full-mask restore brings back every register. A design with the bank order not exactly mirrored would load LAR into D0 and similar swaps. It checks where the padding word sits: a save that padded first, or a restore that padded last, shifts every bank address by 4. A start pulse in the middle of a run must not add operations to the scoreboard or change the final pointer. Masks that differ only in bits 2..0 must behave identically. A zero mask must finish in one cycle without touching memory. A design that wrote the pointer early or decremented after storing shows up as an address or final pointer mismatch.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
    localparam int NSLOT = 12;
    localparam int IDXW  = $clog2(NSLOT);

    typedef logic [3:0] reg_id_t;
    localparam reg_id_t RID_D0  = 4'd0;
    localparam reg_id_t RID_D1  = 4'd1;
    localparam reg_id_t RID_D2  = 4'd2;
    localparam reg_id_t RID_D3  = 4'd3;
    localparam reg_id_t RID_A0  = 4'd4;
    localparam reg_id_t RID_A1  = 4'd5;
    localparam reg_id_t RID_A2  = 4'd6;
    localparam reg_id_t RID_A3  = 4'd7;
    localparam reg_id_t RID_MDR = 4'd8;
    localparam reg_id_t RID_LIR = 4'd9;
    localparam reg_id_t RID_LAR = 4'd10;
    localparam reg_id_t RID_PAD = 4'd15;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_t;

    // Index into mask[7:3] that enables save-order slot s.
    function automatic int slot_sel_bit(int s);
        if (s < 4) return 4 - s;
        return 0;
    endfunction

    // Register held by save-order slot s.
    function automatic reg_id_t slot_reg(int s);
        case (s)
            0:       return RID_D2;
            1:       return RID_D3;
            2:       return RID_A2;
            3:       return RID_A3;
            4:       return RID_D0;
            5:       return RID_D1;
            6:       return RID_A0;
            7:       return RID_A1;
            8:       return RID_MDR;
            9:       return RID_LIR;
            10:      return RID_LAR;
            default: return RID_PAD;
        endcase
    endfunction
endpackage

// File: rtl/regstack_slot_map.sv
module regstack_slot_map
    import regstack_pkg::*;
(
    input  logic [4:0]        sel_hi,
    input  logic              sel_pop,
    output logic [NSLOT-1:0]  en_vec,
    input  logic              lk_pop,
    input  logic [IDXW-1:0]   lk_idx,
    output reg_id_t           lk_rid,
    output logic              lk_pad
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam int SAVE_BIT = slot_sel_bit(g);
        localparam int LOAD_BIT = slot_sel_bit(NSLOT - 1 - g);
        assign en_vec[g] = sel_pop ? sel_hi[LOAD_BIT] : sel_hi[SAVE_BIT];
    end

    always_comb begin
        if (lk_pop) lk_rid = slot_reg(NSLOT - 1 - int'(lk_idx));
        else        lk_rid = slot_reg(int'(lk_idx));
        lk_pad = (lk_rid == RID_PAD);
    end
endmodule

// File: rtl/regstack_pick.sv
module regstack_pick #(
    parameter int W  = 12,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq
    import regstack_pkg::*;
#(
    parameter int DW = 32,
    localparam int STEP = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          pop,
    input  logic [7:0]    mask,
    input  logic [DW-1:0] sp_in,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [3:0]    rf_rd_idx,
    input  logic [DW-1:0] rf_rd_data,
    output logic          rf_we,
    output logic [3:0]    rf_wr_idx,
    output logic [DW-1:0] rf_wr_data,
    output logic          sp_we,
    output logic [DW-1:0] sp_wdata
);
    seq_state_t        state;
    logic [NSLOT-1:0]  pend;
    logic              dir_pop;
    logic [DW-1:0]     cur_sp;

    logic [NSLOT-1:0]  en_vec;
    logic              any_left;
    logic [IDXW-1:0]   slot_idx;
    reg_id_t           slot_rid;
    logic              slot_pad;
    logic [NSLOT-1:0]  pend_nxt;
    logic [DW-1:0]     sp_dn;
    logic [DW-1:0]     sp_up;
    logic              ign_unused_lo;

    assign ign_unused_lo = ^mask[2:0];

    regstack_slot_map u_map (
        .sel_hi  (mask[7:3]),
        .sel_pop (pop),
        .en_vec  (en_vec),
        .lk_pop  (dir_pop),
        .lk_idx  (slot_idx),
        .lk_rid  (slot_rid),
        .lk_pad  (slot_pad)
    );

    regstack_pick #(.W(NSLOT)) u_pick (
        .vec   (pend),
        .found (any_left),
        .idx   (slot_idx)
    );

    assign pend_nxt = pend & ~(NSLOT'(1) << slot_idx);
    assign sp_dn    = cur_sp - DW'(STEP);
    assign sp_up    = cur_sp + DW'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pend    <= '0;
            dir_pop <= 1'b0;
            cur_sp  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pend    <= en_vec;
                        dir_pop <= pop;
                        cur_sp  <= sp_in;
                        state   <= (|en_vec) ? ST_RUN : ST_DONE;
                    end
                end
                ST_RUN: begin
                    pend   <= pend_nxt;
                    cur_sp <= dir_pop ? sp_up : sp_dn;
                    if (pend_nxt == '0 || !any_left) state <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = 1'b0;
        done       = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        rf_rd_idx  = '0;
        rf_we      = 1'b0;
        rf_wr_idx  = '0;
        rf_wr_data = '0;
        sp_we      = 1'b0;
        sp_wdata   = '0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN: begin
                busy = 1'b1;
                if (!slot_pad) begin
                    mem_req = 1'b1;
                    if (dir_pop) begin
                        mem_addr   = cur_sp;
                        rf_we      = 1'b1;
                        rf_wr_idx  = slot_rid;
                        rf_wr_data = mem_rdata;
                    end else begin
                        mem_we    = 1'b1;
                        mem_addr  = sp_dn;
                        rf_rd_idx = slot_rid;
                        mem_wdata = rf_rd_data;
                    end
                end
            end
            ST_DONE: begin
                busy     = 1'b1;
                done     = 1'b1;
                sp_we    = 1'b1;
                sp_wdata = cur_sp;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/regstack_seq_chk.sv
module regstack_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [4:0]  mask_hi,
    input logic        busy,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        rf_we,
    input logic        sp_we
);
    // R1
    save_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && $past(mem_req) |-> mem_addr == $past(mem_addr) - 32'd4);

    // R3
    load_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && $past(mem_req) |-> mem_addr == $past(mem_addr) + 32'd4);

    // R3
    wb_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> mem_req && !mem_we);

    // R5
    sp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> done ##1 !sp_we);

    // R7
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && mask_hi == 5'd0 |=> done && !mem_req);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    // R8
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind regstack_seq regstack_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mask_hi  (mask[7:3]),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .rf_we    (rf_we),
    .sp_we    (sp_we)
);

// File: tb/sim_regstack_seq.sv
module sim_regstack_seq;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pop = 1'b0;
    logic [7:0]  mask = '0;
    logic [31:0] sp_in = '0;
    logic        busy, done, mem_req, mem_we, rf_we, sp_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data, sp_wdata;
    logic [3:0]  rf_rd_idx, rf_wr_idx;

    logic [31:0] rf  [0:10];
    logic [31:0] mem [0:255];

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  rid;
        string       req;
    } op_t;
    op_t expq[$];

    always #(CLK_NS/2) clk = ~clk;

    regstack_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pop(pop), .mask(mask), .sp_in(sp_in),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_rd_idx(rf_rd_idx),
        .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx),
        .rf_wr_data(rf_wr_data), .sp_we(sp_we), .sp_wdata(sp_wdata)
    );

    assign mem_rdata  = mem[mem_addr[9:2]];
    assign rf_rd_data = (rf_rd_idx <= 4'd10) ? rf[rf_rd_idx] : 32'hDEAD_BEEF;

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (rf_we && rf_wr_idx <= 4'd10) rf[rf_wr_idx] <= rf_wr_data;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every memory request.
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (expq.size() == 0) begin
                check(0, "R9", "unexpected memory op addr", mem_addr, 32'h0);
            end else begin
                op_t e;
                e = expq.pop_front();
                check(mem_we == e.we, e.req, "direction", 32'(mem_we), 32'(e.we));
                check(mem_addr == e.addr, e.req, "address", mem_addr, e.addr);
                if (e.we) begin
                    check(mem_wdata == e.data, e.req, "store data", mem_wdata, e.data);
                    check(!rf_we, e.req, "no writeback on store", 32'(rf_we), 32'h0);
                end else begin
                    check(rf_we && rf_wr_idx == e.rid, e.req, "writeback reg",
                          32'(rf_wr_idx), 32'(e.rid));
                    check(rf_wr_data == e.data, e.req, "writeback data", rf_wr_data, e.data);
                end
            end
        end
    end

    // Driver side model: build the expected op list from the requirements.
    task automatic expect_ops(input bit p, input logic [7:0] m, input logic [31:0] sp,
                              output logic [31:0] sp_end, output int nslot);
        logic [3:0] bank_save [7] = '{4'd0, 4'd1, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10};
        logic [3:0] hi_reg [4]    = '{4'd2, 4'd3, 4'd6, 4'd7}; // bits 7,6,5,4
        logic [31:0] s = sp;
        nslot = 0;
        if (!p) begin
            for (int b = 0; b < 4; b++) begin
                if (m[7-b]) begin
                    op_t o;
                    s = s - 4;
                    o.we = 1; o.addr = s; o.data = rf[hi_reg[b]]; o.rid = hi_reg[b]; o.req = "R1";
                    expq.push_back(o); nslot++;
                end
            end
            if (m[3]) begin
                for (int k = 0; k < 7; k++) begin
                    op_t o;
                    s = s - 4;
                    o.we = 1; o.addr = s; o.data = rf[bank_save[k]]; o.rid = bank_save[k]; o.req = "R2";
                    expq.push_back(o); nslot++;
                end
                s = s - 4; nslot++;
            end
        end else begin
            if (m[3]) begin
                s = s + 4; nslot++;
                for (int k = 6; k >= 0; k--) begin
                    op_t o;
                    o.we = 0; o.addr = s; o.data = mem[s[9:2]]; o.rid = bank_save[k]; o.req = "R3";
                    expq.push_back(o); nslot++;
                    s = s + 4;
                end
            end
            for (int b = 3; b >= 0; b--) begin
                if (m[7-b]) begin
                    op_t o;
                    o.we = 0; o.addr = s; o.data = mem[s[9:2]]; o.rid = hi_reg[b]; o.req = "R4";
                    expq.push_back(o); nslot++;
                    s = s + 4;
                end
            end
        end
        sp_end = s;
    endtask

    task automatic run_seq(input bit p, input logic [7:0] m, input logic [31:0] sp,
                           input int extra_at);
        logic [31:0] sp_end;
        int nslot;
        int k;
        bit got;
        expect_ops(p, m, sp, sp_end, nslot);
        start = 1; pop = p; mask = m; sp_in = sp;
        k = 0; got = 0;
        while (!got && k < 40) begin
            @(negedge clk);
            k++;
            if (done) begin
                got = 1;
                check(k == nslot + 1, "R9", "done latency", 32'(k), 32'(nslot + 1));
                check(sp_we && sp_wdata == sp_end, "R5", "final pointer", sp_wdata, sp_end);
                check(expq.size() == 0, "R9", "ops left unissued", 32'(expq.size()), 32'h0);
                if (nslot == 0)
                    check(sp_wdata == sp, "R7", "empty mask pointer", sp_wdata, sp);
            end else begin
                check(busy && !sp_we, "R8", "busy during run", 32'({busy, sp_we}), 32'h2);
            end
            if (k == extra_at) begin
                start = 1; pop = ~p; mask = 8'hFF; sp_in = 32'h0000_0100;
            end else begin
                start = 0;
            end
        end
        check(got, "R9", "done seen", 32'(got), 32'h1);
        start = 0;
        @(negedge clk);
        check(!busy && !done && !mem_req, "R8", "idle after done",
              32'({busy, done, mem_req}), 32'h0);
        expq.delete();
    endtask

    initial begin
        #(CLK_NS * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] saved [0:10];
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
        for (int i = 0; i < 11; i++) rf[i] = 32'h1000_0000 + i * 32'h11;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!busy && !done && !mem_req && !rf_we && !sp_we, "R10", "reset outputs",
              32'({busy, done, mem_req, rf_we, sp_we}), 32'h0);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done, "R10", "idle after reset", 32'({busy, done}), 32'h0);

        run_seq(0, 8'h80, 32'h0000_0200, 0);   // R1 single
        run_seq(0, 8'hF0, 32'h0000_0200, 0);   // R1 order
        run_seq(0, 8'h08, 32'h0000_0240, 0);   // R2 bank + pad
        run_seq(1, 8'h08, 32'h0000_0180, 0);   // R3 bank
        run_seq(1, 8'hF0, 32'h0000_0180, 0);   // R4 order
        run_seq(1, 8'h50, 32'h0000_0120, 0);   // R4 sparse
        run_seq(0, 8'h07, 32'h0000_0300, 0);   // R7 zero mask, R6 low bits
        run_seq(0, 8'h87, 32'h0000_0200, 0);   // R6 low bits ignored
        run_seq(1, 8'h0F, 32'h0000_0180, 0);   // R6 on restore
        run_seq(0, 8'hF8, 32'h0000_0280, 2);   // R8 start while busy

        // R4 round trip
        run_seq(0, 8'hFF, 32'h0000_0300, 0);
        for (int i = 0; i < 11; i++) begin
            saved[i] = rf[i];
            rf[i] = 32'hFFFF_0000 | 32'(i);
        end
        run_seq(1, 8'hFF, 32'h0000_02D0, 0);
        for (int i = 0; i < 11; i++)
            check(rf[i] == saved[i], "R4", "round trip register", rf[i], saved[i]);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule